// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block sits between an external interrupt controller and a processor's program sequencer. It accepts three kinds of request: a maskable request that carries a 3-bit priority level, a non-maskable request, and an internal exception request raised by the core itself. The two external requests pass through a two-stage synchronizer on the core clock. Each source then sets its own pending flag. A source holds at most one request at a time, so further assertions while it is pending are absorbed.

Every cycle the block picks one pending source and presents it to the sequencer together with a 32-bit vector address. Internal exceptions win over non-maskable requests, and non-maskable requests win over maskable ones. A maskable request is only presented while its captured level is strictly above the mask field of the status register. The comparison is made against the current mask, so raising the mask withdraws a request that has not been serviced yet. A mode bit can block the non-maskable input. The vector address is made of the base register, a 6-bit offset and a 64-byte slot. The offset is either a built-in default per class or the external offset bus, as the auto-vector input selects. The sequencer acknowledges the presented request, and that clears the pending flag of that source.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A maskable or non-maskable request held high from just after a rising edge is presented on `svc_req_o` after the third rising edge and not after the second. An internal exception request is presented after the first rising edge.
- R2: A pending maskable request is presented only while its captured level is strictly greater than `sr_mask_i`. An equal or lower level is withheld. The comparison uses the current `sr_mask_i` every cycle, so raising the mask withdraws the request at once and lowering it brings the request back.
- R3: A non-maskable request is presented whatever `mlvl_i` and `sr_mask_i` hold.
- R4: While `nmi_dis_i` is high, the non-maskable input sets no pending request, and nothing from that period is presented later.
- R5: An internal exception is presented regardless of `sr_mask_i` and `nmi_dis_i`.
- R6: Among pending sources the order is internal exception, then non-maskable, then maskable. `svc_src_o` encodes the presented class as 0 for an internal exception, 1 for non-maskable and 2 for maskable.
- R7: While a request is presented, `svc_vec_o` equals {`vbase_i`, 6-bit offset, 6'b0}, with the base in bits 31:12 and the offset in bits 11:6.
- R8: With `autovec_i` high the offset is 0 for an internal exception, 1 for non-maskable, and 8 plus the captured level for maskable. With `autovec_i` low the offset is `ext_off_i` for every class. The level is captured when the pending flag is set, and later changes on `mlvl_i` do not alter it.
- R9: A pending request stays presented until `ack_i` is high on a rising edge while it is presented. That edge clears only the presented source. Extra assertions of a source while it is pending do not queue a second request.
- R10: After reset `svc_req_o`, `svc_src_o` and `svc_vec_o` are all zero. They are also zero whenever nothing is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_i | input | 1 | Maskable request, asynchronous |
| mlvl_i | input | 3 | Priority level of the maskable request |
| nmi_i | input | 1 | Non-maskable request, asynchronous |
| exc_i | input | 1 | Internal exception request, synchronous |
| autovec_i | input | 1 | 1: default offset, 0: external offset |
| ext_off_i | input | 6 | External vector offset |
| sr_mask_i | input | 3 | Mask level from the status register |
| nmi_dis_i | input | 1 | Blocks the non-maskable input |
| vbase_i | input | 20 | Vector base address |
| ack_i | input | 1 | Sequencer accepts the presented request |
| svc_req_o | output | 1 | Service request to the sequencer |
| svc_src_o | output | 2 | Class of the presented request |
| svc_vec_o | output | 32 | Vector address of the presented request |

## Verification
If a pending flag is stuck set, the block shows a service request that an acknowledge cannot remove. If a flag is lost, an expected request never appears. Either fault is visible on `svc_req_o` within one cycle of the acknowledge or the request. A wrongly captured priority level shows up at once in the auto-vector offset bits. It also shows up in whether the request survives a change of mask, because the mask comparison takes effect in the same cycle as the mask change. A synchronizer with the wrong depth moves the first presentation by one cycle. The bench samples that boundary directly.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic [1:0] {
    SRC_EXC = 2'd0,
    SRC_NMI = 2'd1,
    SRC_MSK = 2'd2
  } src_e;

  localparam int unsigned DEF_OFF_EXC = 0;
  localparam int unsigned DEF_OFF_NMI = 1;
  localparam int unsigned DEF_OFF_MSK = 8;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_set_i,
  input  logic             nmi_set_i,
  input  logic             msk_set_i,
  input  logic [LVL_W-1:0] msk_lvl_i,
  input  logic             exc_clr_i,
  input  logic             nmi_clr_i,
  input  logic             msk_clr_i,
  output logic             exc_pend_o,
  output logic             nmi_pend_o,
  output logic             msk_pend_o,
  output logic [LVL_W-1:0] msk_lvl_o
);
  logic             exc_q, nmi_q, msk_q;
  logic [LVL_W-1:0] lvl_q;

  // clear wins over set; set only from idle, so nothing queues
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_q <= 1'b0;
      nmi_q <= 1'b0;
      msk_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      if (exc_clr_i)      exc_q <= 1'b0;
      else if (exc_set_i) exc_q <= 1'b1;

      if (nmi_clr_i)      nmi_q <= 1'b0;
      else if (nmi_set_i) nmi_q <= 1'b1;

      if (msk_clr_i) begin
        msk_q <= 1'b0;
      end else if (msk_set_i && !msk_q) begin
        msk_q <= 1'b1;
        lvl_q <= msk_lvl_i;
      end
    end
  end

  assign exc_pend_o = exc_q;
  assign nmi_pend_o = nmi_q;
  assign msk_pend_o = msk_q;
  assign msk_lvl_o  = lvl_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_accept_pkg::*;
#(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned BASE_W = 20,
  parameter int unsigned SLOT_W = 6,
  localparam int unsigned VEC_W = BASE_W + OFF_W + SLOT_W
) (
  input  logic              exc_pend_i,
  input  logic              nmi_pend_i,
  input  logic              msk_pend_i,
  input  logic [LVL_W-1:0]  msk_lvl_i,
  input  logic [LVL_W-1:0]  sr_mask_i,
  input  logic              autovec_i,
  input  logic [OFF_W-1:0]  ext_off_i,
  input  logic [BASE_W-1:0] vbase_i,
  output logic              req_o,
  output src_e              src_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic             msk_ok;
  logic [OFF_W-1:0] def_off;
  logic [OFF_W-1:0] off;

  assign msk_ok = msk_pend_i && (msk_lvl_i > sr_mask_i);

  always_comb begin
    req_o   = 1'b1;
    src_o   = SRC_EXC;
    def_off = OFF_W'(DEF_OFF_EXC);
    if (exc_pend_i) begin
      src_o   = SRC_EXC;
      def_off = OFF_W'(DEF_OFF_EXC);
    end else if (nmi_pend_i) begin
      src_o   = SRC_NMI;
      def_off = OFF_W'(DEF_OFF_NMI);
    end else if (msk_ok) begin
      src_o   = SRC_MSK;
      def_off = OFF_W'(DEF_OFF_MSK) + OFF_W'(msk_lvl_i);
    end else begin
      req_o   = 1'b0;
    end
  end

  assign off   = autovec_i ? def_off : ext_off_i;
  assign vec_o = req_o ? {vbase_i, off, {SLOT_W{1'b0}}} : '0;
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned OFF_W    = 6,
  parameter int unsigned BASE_W   = 20,
  parameter int unsigned SLOT_W   = 6,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             mreq_i,
  input  logic [LVL_W-1:0]                 mlvl_i,
  input  logic                             nmi_i,
  input  logic                             exc_i,
  input  logic                             autovec_i,
  input  logic [OFF_W-1:0]                 ext_off_i,
  input  logic [LVL_W-1:0]                 sr_mask_i,
  input  logic                             nmi_dis_i,
  input  logic [BASE_W-1:0]                vbase_i,
  input  logic                             ack_i,
  output logic                             svc_req_o,
  output logic [1:0]                       svc_src_o,
  output logic [BASE_W+OFF_W+SLOT_W-1:0]   svc_vec_o
);
  localparam int unsigned SW = LVL_W + 2;

  logic [SW-1:0]    sync_d, sync_q;
  logic             s_mreq, s_nmi;
  logic [LVL_W-1:0] s_lvl;
  logic             exc_pend, nmi_pend, msk_pend;
  logic [LVL_W-1:0] msk_lvl;
  src_e             src;
  logic             take;

  assign sync_d = {mreq_i, nmi_i, mlvl_i};

  irq_sync #(.W(SW), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign s_mreq = sync_q[SW-1];
  assign s_nmi  = sync_q[SW-2];
  assign s_lvl  = sync_q[LVL_W-1:0];

  assign take = ack_i && svc_req_o;

  irq_pend #(.LVL_W(LVL_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exc_set_i (exc_i),
    .nmi_set_i (s_nmi && !nmi_dis_i),
    .msk_set_i (s_mreq),
    .msk_lvl_i (s_lvl),
    .exc_clr_i (take && (src == SRC_EXC)),
    .nmi_clr_i (take && (src == SRC_NMI)),
    .msk_clr_i (take && (src == SRC_MSK)),
    .exc_pend_o(exc_pend),
    .nmi_pend_o(nmi_pend),
    .msk_pend_o(msk_pend),
    .msk_lvl_o (msk_lvl)
  );

  irq_arb #(
    .LVL_W (LVL_W),
    .OFF_W (OFF_W),
    .BASE_W(BASE_W),
    .SLOT_W(SLOT_W)
  ) u_arb (
    .exc_pend_i(exc_pend),
    .nmi_pend_i(nmi_pend),
    .msk_pend_i(msk_pend),
    .msk_lvl_i (msk_lvl),
    .sr_mask_i (sr_mask_i),
    .autovec_i (autovec_i),
    .ext_off_i (ext_off_i),
    .vbase_i   (vbase_i),
    .req_o     (svc_req_o),
    .src_o     (src),
    .vec_o     (svc_vec_o)
  );

  assign svc_src_o = svc_req_o ? src : 2'd0;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned BASE_W = 20,
  parameter int unsigned SLOT_W = 6
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           svc_req_o,
  input logic [1:0]                     svc_src_o,
  input logic [BASE_W+OFF_W+SLOT_W-1:0] svc_vec_o,
  input logic [BASE_W-1:0]              vbase_i,
  input logic [OFF_W-1:0]               ext_off_i,
  input logic                           autovec_i,
  input logic [LVL_W-1:0]               sr_mask_i,
  input logic                           ack_i,
  input logic                           exc_i,
  input logic                           exc_pend
);
  localparam int unsigned OL = SLOT_W;

  p_vec_layout_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_req_o |-> (svc_vec_o[OL+OFF_W +: BASE_W] == vbase_i) && (svc_vec_o[SLOT_W-1:0] == '0));

  p_ext_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_req_o && !autovec_i) |-> (svc_vec_o[OL +: OFF_W] == ext_off_i));

  p_mask_strict_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_req_o && autovec_i && svc_src_o == 2'd2)
      |-> (int'(svc_vec_o[OL +: OFF_W]) - 8 > int'(sr_mask_i)));

  p_exc_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_pend |-> (svc_req_o && svc_src_o == 2'd0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_req_o && svc_src_o == 2'd0 && !ack_i) |=> (svc_req_o && svc_src_o == 2'd0));

  p_ack_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_req_o && svc_src_o == 2'd0 && ack_i && !exc_i) |=> !exc_pend);

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svc_req_o |-> (svc_src_o == 2'd0 && svc_vec_o == '0));
endmodule

bind irq_accept_ctrl irq_accept_chk #(
  .LVL_W(LVL_W), .OFF_W(OFF_W), .BASE_W(BASE_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .svc_req_o(svc_req_o),
  .svc_src_o(svc_src_o),
  .svc_vec_o(svc_vec_o),
  .vbase_i  (vbase_i),
  .ext_off_i(ext_off_i),
  .autovec_i(autovec_i),
  .sr_mask_i(sr_mask_i),
  .ack_i    (ack_i),
  .exc_i    (exc_i),
  .exc_pend (exc_pend)
);

// File: tb/sim_irq_accept_ctrl.sv
`timescale 1ns/1ps
module sim_irq_accept_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mreq_i = 0, nmi_i = 0, exc_i = 0, autovec_i = 1, nmi_dis_i = 0, ack_i = 0;
  logic [2:0]  mlvl_i = 0, sr_mask_i = 0;
  logic [5:0]  ext_off_i = 6'h2a;
  logic [19:0] vbase_i = 20'habcde;
  logic        svc_req_o;
  logic [1:0]  svc_src_o;
  logic [31:0] svc_vec_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  irq_accept_ctrl u0 (
    .clk_i, .rst_ni, .mreq_i, .mlvl_i, .nmi_i, .exc_i, .autovec_i, .ext_off_i,
    .sr_mask_i, .nmi_dis_i, .vbase_i, .ack_i, .svc_req_o, .svc_src_o, .svc_vec_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vec(input logic [5:0] off);
    return {vbase_i, off, 6'b0};
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic t_reset();
    #2;
    chk("R10 req in reset", 32'(svc_req_o), 0);
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
    chk("R10 req", 32'(svc_req_o), 0);
    chk("R10 src", 32'(svc_src_o), 0);
    chk("R10 vec", svc_vec_o, 0);
  endtask

  task automatic t_latency();
    nmi_i = 1'b1;
    cyc(2);
    chk("R1 nmi after 2 edges", 32'(svc_req_o), 0);
    cyc(1);
    chk("R1 nmi after 3 edges", 32'(svc_req_o), 1);
    chk("R1 nmi src", 32'(svc_src_o), 1);
    chk("R8 nmi default off", svc_vec_o, vec(6'd1));
    nmi_i = 1'b0;
    cyc(3);
    do_ack();
    chk("R9 nmi cleared", 32'(svc_req_o), 0);
    exc_i = 1'b1;
    cyc(1);
    exc_i = 1'b0;
    chk("R1 exc after 1 edge", 32'(svc_req_o), 1);
    chk("R8 exc default off", svc_vec_o, vec(6'd0));
    do_ack();
    chk("R9 exc cleared", 32'(svc_req_o), 0);
  endtask

  task automatic t_mask();
    sr_mask_i = 3'd3; mlvl_i = 3'd3; mreq_i = 1'b1;
    cyc(5);
    chk("R2 equal level withheld", 32'(svc_req_o), 0);
    sr_mask_i = 3'd2;
    cyc(1);
    chk("R2 mask lowered", 32'(svc_req_o), 1);
    chk("R6 msk src", 32'(svc_src_o), 2);
    chk("R8 msk default off", svc_vec_o, vec(6'd11));
    mlvl_i = 3'd6;
    cyc(4);
    chk("R8 level captured", svc_vec_o, vec(6'd11));
    sr_mask_i = 3'd3;
    cyc(1);
    chk("R2 mask raised withdraws", 32'(svc_req_o), 0);
    mreq_i = 1'b0; sr_mask_i = 3'd0;
    cyc(3);
    chk("R2 back after mask drop", 32'(svc_req_o), 1);
    do_ack();
    chk("R9 msk cleared", 32'(svc_req_o), 0);
    sr_mask_i = 3'd5; mlvl_i = 3'd2; mreq_i = 1'b1;
    cyc(5);
    chk("R2 lower level withheld", 32'(svc_req_o), 0);
    mreq_i = 1'b0; sr_mask_i = 3'd1;
    cyc(3);
    chk("R8 msk off lvl2", svc_vec_o, vec(6'd10));
    do_ack();
    sr_mask_i = 3'd0;
    cyc(1);
    chk("R9 msk cleared 2", 32'(svc_req_o), 0);
  endtask

  task automatic t_nmi();
    sr_mask_i = 3'd7; mlvl_i = 3'd0; nmi_i = 1'b1;
    cyc(4);
    chk("R3 nmi ignores mask", 32'(svc_req_o), 1);
    chk("R3 nmi src", 32'(svc_src_o), 1);
    nmi_i = 1'b0;
    cyc(3);
    do_ack();
    nmi_dis_i = 1'b1; nmi_i = 1'b1;
    cyc(5);
    chk("R4 nmi disabled", 32'(svc_req_o), 0);
    nmi_i = 1'b0;
    cyc(3);
    nmi_dis_i = 1'b0;
    cyc(2);
    chk("R4 nothing latent", 32'(svc_req_o), 0);
  endtask

  task automatic t_exc();
    sr_mask_i = 3'd7; nmi_dis_i = 1'b1; exc_i = 1'b1;
    cyc(1);
    exc_i = 1'b0;
    chk("R5 exc despite mask and disable", 32'(svc_req_o), 1);
    chk("R5 exc src", 32'(svc_src_o), 0);
    do_ack();
    nmi_dis_i = 1'b0; sr_mask_i = 3'd0;
    chk("R5 exc cleared", 32'(svc_req_o), 0);
  endtask

  task automatic t_prio();
    mlvl_i = 3'd7; mreq_i = 1'b1; nmi_i = 1'b1; exc_i = 1'b1;
    cyc(1);
    exc_i = 1'b0;
    cyc(3);
    chk("R6 exc first", 32'(svc_src_o), 0);
    mreq_i = 1'b0; nmi_i = 1'b0;
    cyc(3);
    do_ack();
    chk("R6 nmi second", 32'(svc_src_o), 1);
    chk("R6 nmi req", 32'(svc_req_o), 1);
    do_ack();
    chk("R6 msk third", 32'(svc_src_o), 2);
    chk("R8 msk lvl7 off", svc_vec_o, vec(6'd15));
    do_ack();
    chk("R6 all served", 32'(svc_req_o), 0);
  endtask

  task automatic t_vec();
    autovec_i = 1'b0; vbase_i = 20'h12345; ext_off_i = 6'h2a;
    exc_i = 1'b1;
    cyc(1);
    exc_i = 1'b0;
    chk("R7 ext off exc", svc_vec_o, 32'h1234_5a80);
    ext_off_i = 6'h15;
    cyc(1);
    chk("R8 ext off follows bus", svc_vec_o, vec(6'h15));
    do_ack();
    mlvl_i = 3'd4; mreq_i = 1'b1;
    cyc(4);
    mreq_i = 1'b0;
    chk("R8 ext off msk", svc_vec_o, vec(6'h15));
    cyc(3);
    do_ack();
    autovec_i = 1'b1;
    chk("R9 msk cleared 3", 32'(svc_req_o), 0);
  endtask

  task automatic t_noqueue();
    exc_i = 1'b1;
    cyc(1);
    exc_i = 1'b0;
    cyc(2);
    exc_i = 1'b1;
    cyc(1);
    exc_i = 1'b0;
    cyc(10);
    chk("R9 held without ack", 32'(svc_req_o), 1);
    do_ack();
    cyc(2);
    chk("R9 no second request queued", 32'(svc_req_o), 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_mask();
    t_nmi();
    t_exc();
    t_prio();
    t_vec();
    t_noqueue();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100us;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule